// File: doc/BRIEF.md
# Legacy Display Decode Snoop Filter

This block lives inside a bridge and decides, for each transaction heading to the downstream side, whether the bridge should claim it as a legacy display cycle. The block does not use a fixed decode of every legacy display range. It keeps shadow copies of the address-select bits that the downstream display controller itself uses, and it updates them by watching the I/O writes that program those bits.

Two shadows drive the claim decision. The first is the colour/monochrome I/O select bit, written through the miscellaneous output port. The second is the two-bit memory map field of graphics controller register 6, reached through an index/data port pair. Because the claim follows these shadows, cycles for a separate monochrome adapter are left unclaimed, so a subtractive decoder elsewhere can pick them up.

The claim flag is combinational from the current transaction and the present shadows. Shadow updates take effect on the clock edge that ends the qualifying write.

Top module: `vga_legacy_claim`

## Requirements
- R1: After reset, the I/O select shadow is 0 (monochrome), the memory map shadow is 00 and the captured graphics index is 0. In this state, ports 3B0h–3BFh and memory A0000h–BFFFFh are claimed, and ports 3D0h–3DFh are not.
- R2: Bus lane convention: `txn_addr` gives the word address, and its low log2(bytes per word) bits are ignored. The byte at I/O address A travels on lane A mod 4, which is data bits 8*(A mod 4)+7 down to 8*(A mod 4), with byte enable bit A mod 4. An I/O write with lane 2 enabled to the word holding port 3C2h loads the I/O select shadow from data bit 16.
- R3: With the I/O select shadow at 0, ports 3B0h–3BFh are claimed and 3D0h–3DFh are not. With it at 1, the reverse holds.
- R4: Ports 3C0h–3CFh are claimed whenever the enable is set, whatever the shadows hold.
- R5: Memory claim windows by map shadow value: 00 claims A0000h–BFFFFh; 01 claims A0000h–AFFFFh; 10 claims B0000h–B7FFFh; 11 claims B8000h–BFFFFh.
- R6: An I/O write of lane 2 to port 3CEh captures the graphics index from bits 23:16. An I/O write of lane 3 to port 3CFh loads the map shadow from data bits 27:26 (register bits 3:2), but only while the index in force equals 6.
- R7: A write to the 3CCh word with lanes 2 and 3 both enabled uses the lane 2 byte as the index and the lane 3 byte as the data. The new index decides in that same cycle whether the data is applied.
- R8: Reads, memory-type writes and writes whose relevant byte lane is disabled leave every shadow unchanged. This includes reads of the read-back port 3CCh.
- R9: While the enable is clear, nothing is claimed and no shadow changes.
- R10: I/O ports are compared on the full address, so any nonzero bit above bit 15 prevents a claim. I/O ports outside 3B0h–3DFh and memory outside the selected window are not claimed.
- R11: The claim follows the current inputs with no clock edge in between, and it is low when `txn_valid` is low. A shadow write affects claims from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_addr | input | 32 | Word address of the transaction |
| txn_be | input | 4 | Active-high byte enables, one per lane |
| txn_wdata | input | 32 | Write data |
| vga_enable | input | 1 | Bridge legacy display forwarding enable |
| claim | output | 1 | The bridge claims this transaction |

## Verification
Index capture and graphics-data capture can happen in the same cycle, when one word write to the 3CCh word enables both lane 2 and lane 3. The bench provokes this twice. One write carries index 6 in the low byte and a new map value in the high byte. The other carries index 5 with a different map value. The result is judged by the memory claims that follow: the first write must move the claim window, and the second must leave it where it was, even though the index shadow held 6 just before.

// File: rtl/vgaf_pkg.sv
package vgaf_pkg;

  typedef enum logic [1:0] {
    MAP_A0_BF = 2'b00,
    MAP_A0_AF = 2'b01,
    MAP_B0_B7 = 2'b10,
    MAP_B8_BF = 2'b11
  } memmap_e;

  typedef struct packed {
    logic       color_io;
    memmap_e    map;
    logic [7:0] gc_index;
  } shadow_t;

  localparam logic [15:0] PORT_MISC_WR = 16'h03C2;
  localparam logic [15:0] PORT_GC_IDX  = 16'h03CE;
  localparam logic [15:0] PORT_GC_DAT  = 16'h03CF;
  localparam logic [7:0]  GC_MAP_INDEX = 8'd6;

  localparam logic [11:0] IO_GRP_MONO  = 12'h03B;
  localparam logic [11:0] IO_GRP_VGA   = 12'h03C;
  localparam logic [11:0] IO_GRP_COLOR = 12'h03D;

  // 32 KiB blocks of the legacy memory window
  localparam int          MEM_BLK_SHIFT = 15;
  localparam int unsigned BLK_A0 = 32'h14;
  localparam int unsigned BLK_A8 = 32'h15;
  localparam int unsigned BLK_B0 = 32'h16;
  localparam int unsigned BLK_B8 = 32'h17;

endpackage

// File: rtl/vgaf_rst_sync.sv
module vgaf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vgaf_snoop.sv
module vgaf_snoop
  import vgaf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_qual,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output shadow_t             shd
);
  localparam int BE_W     = DATA_W / 8;
  localparam int LANE_W   = $clog2(BE_W);
  localparam int MISC_LN  = int'(PORT_MISC_WR) % BE_W;
  localparam int IDX_LN   = int'(PORT_GC_IDX) % BE_W;
  localparam int DAT_LN   = int'(PORT_GC_DAT) % BE_W;

  shadow_t    shd_q, shd_d;
  logic       io_hi_zero;
  logic       misc_wr, idx_wr, dat_wr;
  logic [7:0] misc_byte, idx_byte, dat_byte;
  logic [7:0] idx_eff;

  assign io_hi_zero = ((addr >> 16) == '0);
  assign misc_byte  = wdata[MISC_LN*8 +: 8];
  assign idx_byte   = wdata[IDX_LN*8 +: 8];
  assign dat_byte   = wdata[DAT_LN*8 +: 8];

  assign misc_wr = wr_qual && io_hi_zero && be[MISC_LN] &&
                   (addr[15:LANE_W] == PORT_MISC_WR[15:LANE_W]);
  assign idx_wr  = wr_qual && io_hi_zero && be[IDX_LN] &&
                   (addr[15:LANE_W] == PORT_GC_IDX[15:LANE_W]);
  assign dat_wr  = wr_qual && io_hi_zero && be[DAT_LN] &&
                   (addr[15:LANE_W] == PORT_GC_DAT[15:LANE_W]);

  // next-state: index captured in this cycle takes part in the data decision
  always_comb begin
    shd_d   = shd_q;
    idx_eff = shd_q.gc_index;
    if (idx_wr) begin
      shd_d.gc_index = idx_byte;
      idx_eff        = idx_byte;
    end
    if (misc_wr) shd_d.color_io = misc_byte[0];
    if (dat_wr && (idx_eff == GC_MAP_INDEX)) shd_d.map = memmap_e'(dat_byte[3:2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q.color_io <= 1'b0;
      shd_q.map      <= MAP_A0_BF;
      shd_q.gc_index <= 8'h00;
    end else if (wr_qual) begin
      shd_q <= shd_d;
    end
  end

  assign shd = shd_q;

  // R8 / R9: no qualifying write, no shadow movement
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_qual |=> $stable(shd_q));

  // R2: a misc write lands bit 0 of its lane in the select shadow
  assert_misc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> (shd_q.color_io == $past(misc_byte[0])));

  // R6: a data-port write with a non-6 index in force never moves the map
  assert_map_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_wr && (shd_q.gc_index != GC_MAP_INDEX)) |=> $stable(shd_q.map));
endmodule

// File: rtl/vgaf_claim.sv
module vgaf_claim
  import vgaf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              is_io,
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic              color_io,
  input  memmap_e           map,
  output logic              claim
);
  localparam logic [ADDR_W-1:0] B_A0 = ADDR_W'(BLK_A0);
  localparam logic [ADDR_W-1:0] B_A8 = ADDR_W'(BLK_A8);
  localparam logic [ADDR_W-1:0] B_B0 = ADDR_W'(BLK_B0);
  localparam logic [ADDR_W-1:0] B_B8 = ADDR_W'(BLK_B8);

  logic              io_hi_zero;
  logic [11:0]       io_grp;
  logic [ADDR_W-1:0] blk;
  logic              in_a, in_b0, in_b8;
  logic              io_hit, mem_hit;

  assign io_hi_zero = ((addr >> 16) == '0);
  assign io_grp     = addr[15:4];
  assign blk        = addr >> MEM_BLK_SHIFT;
  assign in_a       = (blk == B_A0) || (blk == B_A8);
  assign in_b0      = (blk == B_B0);
  assign in_b8      = (blk == B_B8);

  always_comb begin
    io_hit = 1'b0;
    if (io_hi_zero) begin
      unique case (io_grp)
        IO_GRP_MONO:  io_hit = !color_io;
        IO_GRP_VGA:   io_hit = 1'b1;
        IO_GRP_COLOR: io_hit = color_io;
        default:      io_hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (map)
      MAP_A0_BF: mem_hit = in_a || in_b0 || in_b8;
      MAP_A0_AF: mem_hit = in_a;
      MAP_B0_B7: mem_hit = in_b0;
      MAP_B8_BF: mem_hit = in_b8;
      default:   mem_hit = 1'b0;
    endcase
  end

  assign claim = valid && enable && (is_io ? io_hit : mem_hit);

  // R9: no claim without the enable
  assert_no_claim_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> enable);

  // R5: memory claims stay inside the 128 KiB legacy window
  assert_mem_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !is_io) |-> ((addr >= ADDR_W'(32'hA0000)) && (addr <= ADDR_W'(32'hBFFFF))));

  // R10: no I/O claim on an address with upper bits set
  assert_io_no_alias_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && is_io) |-> ((addr >> 16) == '0));

  // R3: monochrome ports are refused in colour mode
  assert_mono_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_io && color_io && (addr[ADDR_W-1:4] == ADDR_W'(32'h3B) >> 0)) |-> !claim);

  // R4: the always-on register block is claimed when enabled
  assert_vga_ports_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && enable && is_io && (addr[ADDR_W-1:4] == (ADDR_W-4)'(32'h3C))) |-> claim);
endmodule

// File: rtl/vga_legacy_claim.sv
module vga_legacy_claim
  import vgaf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_valid,
  input  logic                txn_is_io,
  input  logic                txn_write,
  input  logic [ADDR_W-1:0]   txn_addr,
  input  logic [DATA_W/8-1:0] txn_be,
  input  logic [DATA_W-1:0]   txn_wdata,
  input  logic                vga_enable,
  output logic                claim
);
  logic    rst_sync_n;
  logic    wr_qual;
  shadow_t shd;

  vgaf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_qual = txn_valid && txn_is_io && txn_write && vga_enable;

  vgaf_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snoop (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_qual (wr_qual),
    .addr    (txn_addr),
    .be      (txn_be),
    .wdata   (txn_wdata),
    .shd     (shd)
  );

  vgaf_claim #(.ADDR_W(ADDR_W)) u_claim (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .valid    (txn_valid),
    .is_io    (txn_is_io),
    .enable   (vga_enable),
    .addr     (txn_addr),
    .color_io (shd.color_io),
    .map      (shd.map),
    .claim    (claim)
  );
endmodule

// File: tb/vga_legacy_claim_test.sv
module vga_legacy_claim_test;
  typedef struct packed {
    logic        io;
    logic        wr;
    logic        en;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b1,32'h3B4,  4'b0001,32'h0,        1'b1,8'd1},  // R1 mono default
    '{1'b1,1'b0,1'b1,32'h3D4,  4'b0001,32'h0,        1'b0,8'd1},  // R1
    '{1'b0,1'b0,1'b1,32'hA0000,4'b1111,32'h0,        1'b1,8'd1},  // R1 map 00
    '{1'b0,1'b0,1'b1,32'hB8000,4'b1111,32'h0,        1'b1,8'd5},  // R5
    '{1'b0,1'b0,1'b1,32'hC0000,4'b1111,32'h0,        1'b0,8'd10}, // R10
    '{1'b1,1'b0,1'b1,32'h3CC,  4'b0001,32'h0,        1'b1,8'd4},  // R4
    '{1'b1,1'b1,1'b1,32'h3C0,  4'b0100,32'h0001_0000,1'b1,8'd2},  // R2 set colour
    '{1'b1,1'b0,1'b1,32'h3D4,  4'b0001,32'h0,        1'b1,8'd3},  // R3
    '{1'b1,1'b0,1'b1,32'h3B4,  4'b0001,32'h0,        1'b0,8'd3},  // R3
    '{1'b1,1'b1,1'b1,32'h3C0,  4'b0011,32'h0,        1'b1,8'd8},  // R8 lane off
    '{1'b1,1'b0,1'b1,32'h3D8,  4'b0100,32'h0,        1'b1,8'd8},  // R8 still colour
    '{1'b1,1'b1,1'b1,32'h3CC,  4'b0100,32'h0006_0000,1'b1,8'd6},  // R6 index 6
    '{1'b1,1'b1,1'b1,32'h3CC,  4'b1000,32'h0800_0000,1'b1,8'd6},  // R6 map 10
    '{1'b0,1'b0,1'b1,32'hA0000,4'b1111,32'h0,        1'b0,8'd5},  // R5
    '{1'b0,1'b0,1'b1,32'hB0000,4'b1111,32'h0,        1'b1,8'd5},  // R5
    '{1'b0,1'b0,1'b1,32'hB7FFC,4'b1111,32'h0,        1'b1,8'd5},  // R5
    '{1'b0,1'b0,1'b1,32'hB8000,4'b1111,32'h0,        1'b0,8'd5},  // R5
    '{1'b1,1'b1,1'b1,32'h3CC,  4'b0100,32'h0005_0000,1'b1,8'd6},  // R6 index 5
    '{1'b1,1'b1,1'b1,32'h3CC,  4'b1000,32'h0C00_0000,1'b1,8'd6},  // R6 ignored
    '{1'b0,1'b0,1'b1,32'hB0000,4'b1111,32'h0,        1'b1,8'd6},  // R6
    '{1'b0,1'b0,1'b1,32'hB8000,4'b1111,32'h0,        1'b0,8'd6},  // R6
    '{1'b1,1'b1,1'b1,32'h3CC,  4'b1100,32'h0C06_0000,1'b1,8'd7},  // R7 map 11
    '{1'b0,1'b0,1'b1,32'hB8000,4'b1111,32'h0,        1'b1,8'd7},  // R7
    '{1'b0,1'b0,1'b1,32'hB0000,4'b1111,32'h0,        1'b0,8'd7},  // R7
    '{1'b0,1'b0,1'b1,32'hBFFFC,4'b1111,32'h0,        1'b1,8'd5},  // R5
    '{1'b0,1'b0,1'b1,32'hAFFFC,4'b1111,32'h0,        1'b0,8'd5},  // R5
    '{1'b1,1'b1,1'b1,32'h3CC,  4'b1100,32'h0405_0000,1'b1,8'd7},  // R7 idx 5 blocks
    '{1'b0,1'b0,1'b1,32'hB8000,4'b1111,32'h0,        1'b1,8'd7},  // R7
    '{1'b1,1'b0,1'b1,32'h3CC,  4'b0001,32'h0,        1'b1,8'd8},  // R8 readback
    '{1'b1,1'b0,1'b1,32'h3B4,  4'b0001,32'h0,        1'b0,8'd8},  // R8
    '{1'b1,1'b1,1'b1,32'h3CC,  4'b1100,32'h0406_0000,1'b1,8'd7},  // R7 map 01
    '{1'b0,1'b0,1'b1,32'hA8000,4'b1111,32'h0,        1'b1,8'd5},  // R5
    '{1'b0,1'b0,1'b1,32'hB0000,4'b1111,32'h0,        1'b0,8'd5},  // R5
    '{1'b1,1'b0,1'b1,32'h13D4, 4'b0001,32'h0,        1'b0,8'd10}, // R10 not 3Dx
    '{1'b1,1'b0,1'b1,32'h103D4,4'b0001,32'h0,        1'b0,8'd10}, // R10 alias
    '{1'b1,1'b0,1'b1,32'h3E0,  4'b0001,32'h0,        1'b0,8'd10}, // R10
    '{1'b1,1'b0,1'b1,32'h3AC,  4'b0001,32'h0,        1'b0,8'd10}, // R10
    '{1'b1,1'b0,1'b0,32'h3C4,  4'b0001,32'h0,        1'b0,8'd9},  // R9
    '{1'b0,1'b0,1'b0,32'hA8000,4'b1111,32'h0,        1'b0,8'd9},  // R9
    '{1'b1,1'b1,1'b0,32'h3C0,  4'b0100,32'h0,        1'b0,8'd9},  // R9 no update
    '{1'b1,1'b0,1'b1,32'h3D4,  4'b0001,32'h0,        1'b1,8'd9},  // R9
    '{1'b1,1'b1,1'b0,32'h3CC,  4'b1100,32'h0006_0000,1'b0,8'd9},  // R9 no update
    '{1'b0,1'b0,1'b1,32'hB0000,4'b1111,32'h0,        1'b0,8'd9},  // R9 map 01 kept
    '{1'b0,1'b0,1'b1,32'hA0000,4'b1111,32'h0,        1'b1,8'd9},  // R9
    '{1'b0,1'b1,1'b1,32'h3C0,  4'b0100,32'h0,        1'b0,8'd8},  // R8 mem write
    '{1'b1,1'b0,1'b1,32'h3D4,  4'b0001,32'h0,        1'b1,8'd8},  // R8
    '{1'b1,1'b1,1'b1,32'h3C0,  4'b0100,32'h0,        1'b1,8'd2},  // R2 back to mono
    '{1'b1,1'b0,1'b1,32'h3B0,  4'b0001,32'h0,        1'b1,8'd2},  // R2
    '{1'b1,1'b0,1'b1,32'h3BC,  4'b0001,32'h0,        1'b1,8'd3},  // R3
    '{1'b1,1'b0,1'b1,32'h3DC,  4'b0001,32'h0,        1'b0,8'd3},  // R3
    '{1'b1,1'b0,1'b1,32'h3C8,  4'b1000,32'h0,        1'b1,8'd4}   // R4
  };

  logic        clk;
  logic        rst_n;
  logic        txn_valid, txn_is_io, txn_write, vga_enable;
  logic [31:0] txn_addr, txn_wdata;
  logic [3:0]  txn_be;
  logic        claim;
  int          checks, fails;
  logic        done;

  vga_legacy_claim uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_valid  (txn_valid),
    .txn_is_io  (txn_is_io),
    .txn_write  (txn_write),
    .txn_addr   (txn_addr),
    .txn_be     (txn_be),
    .txn_wdata  (txn_wdata),
    .vga_enable (vga_enable),
    .claim      (claim)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic io, input logic wr, input logic en,
                       input logic [31:0] a, input logic [3:0] b, input logic [31:0] d);
    txn_valid  = 1'b1;
    txn_is_io  = io;
    txn_write  = wr;
    vga_enable = en;
    txn_addr   = a;
    txn_be     = b;
    txn_wdata  = d;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 32'h0, 4'b0, 32'h0);
    txn_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: idle bus claims nothing
    #2 chk("R11 idle", claim, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].io, TBL[i].wr, TBL[i].en, TBL[i].addr, TBL[i].be, TBL[i].wd);
      #2;
      checks++;
      if (claim !== TBL[i].exp) begin
        fails++;
        $display("FAIL vector %0d R%0d actual=%0b expected=%0b", i, TBL[i].req, claim, TBL[i].exp);
      end
    end

    // R11: claim follows the address without a clock edge
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 32'h3D4, 4'b0001, 32'h0);
    #1 chk("R11 comb 3D4 mono", claim, 1'b0);
    txn_addr = 32'h3B4;
    #1 chk("R11 comb 3B4 mono", claim, 1'b1);
    txn_valid = 1'b0;
    #1 chk("R11 valid low", claim, 1'b0);

    // R1: put shadows away from reset values, then reset mid-run
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 32'h3C0, 4'b0100, 32'h0001_0000);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 32'h3CC, 4'b1100, 32'h0806_0000);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 32'h3D4, 4'b0001, 32'h0);
    #2 chk("R1 pre-reset colour", claim, 1'b1);
    txn_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 32'h3D4, 4'b0001, 32'h0);
    #2 chk("R1 reset 3D4", claim, 1'b0);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 32'h3B4, 4'b0001, 32'h0);
    #2 chk("R1 reset 3B4", claim, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 32'hA0000, 4'b1111, 32'h0);
    #2 chk("R1 reset A0000", claim, 1'b1);
    // R1: index shadow is 0 after reset, so a lone data write is ignored
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 32'h3CC, 4'b1000, 32'h0C00_0000);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 32'hA0000, 4'b1111, 32'h0);
    #2 chk("R1 index reset A0000", claim, 1'b1);

    @(negedge clk);
    txn_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule